// File: doc/BRIEF.md
# Multi-CPU Interrupt Controller with Claim-on-Read Masking

This block collects a set of level-sensitive, active-high hardware interrupt lines and distributes them to a small number of processors. Every line can also be raised by software: a trigger bit per line is ORed with the wire. Each line has a single enable mask bit and a per-line routing bitmask with one bit per CPU. A CPU's request output is high while something eligible is waiting for it. Each CPU also owns two inter-processor flags. The "other" flag is raised by any CPU through a send register that takes a target bitmask. The "self" flag is raised through the CPU's own register page. Apart from their numbers and their priority order, the two flags behave the same way.

A CPU services its request by reading its event register. The read returns the most urgent source and claims it in the same clock. Inter-processor flags come first, then hardware lines, and a lower line number wins over a higher one. Claiming a hardware line sets its mask bit, and software clears that bit again once the line is handled. Claiming an inter-processor flag clears the flag. When a line is routed to several CPUs, all of them see the request, but only the first read takes it. The register space is split into pages. Page 0 serves whichever CPU issued the access, as given by the `bus_cpu` input. Page c+1 serves CPU c explicitly. Mask, trigger and inter-processor flags each have their own set and clear addresses, so single bits change atomically.

Top module: `mp_intc`

## Requirements
- R1: After a synchronous reset every mask bit is 1, all software triggers and inter-processor flags are 0, every line's routing mask is 1 (CPU 0 only), `cpu_irq` is 0 and `rdata` is 0.
- R2: A line is pending when its hardware input or its software trigger is 1. Writing 1-bits to trigger-set (offset 0x13) or trigger-clear (0x14) sets or clears only those triggers. The trigger word reads at 0x15 and the pending word at 0x16.
- R3: A masked line never raises any `cpu_irq`. `cpu_irq` is registered, so it follows the controller state with one clock of delay.
- R4: `cpu_irq[c]` is 1 exactly when CPU c has an inter-processor flag set or some pending, unmasked line whose routing mask (offset 0x40+i, bit c) includes CPU c.
- R5: A read of the event register (offset 0x00) returns bit 31 = 1, bits 17:16 = the kind (0 for a hardware line, 2 for an inter-processor flag) and bits 15:0 = the number of the lowest-numbered eligible line. All other bits are 0. `rdata` is valid in the clock after `rd_en`.
- R6: An event read that returns a hardware line sets that line's mask bit in the same clock, so no other CPU can claim it afterwards.
- R7: Inter-processor flags take priority over hardware lines. The "other" flag (number 0) comes before the "self" flag (number 1), and an event read that returns a flag clears it.
- R8: An event read with nothing eligible returns 0 and changes no state.
- R9: Page 0 addresses the CPU named on `bus_cpu`. Page c+1 addresses CPU c, whatever `bus_cpu` is. The address is {page[ADDR_W-1:8], offset[7:0]}.
- R10: Writing 1-bits to mask-set (0x10) or mask-clear (0x11) changes only those mask bits. The mask word reads at 0x12.
- R11: A write to 0x01 sets the "other" flag of every CPU whose bit is 1 in the write data. Writing bit 0 of 0x02 sets the "self" flag of the page's CPU. Writing 0x03 clears that CPU's flags wherever a data bit is 1 (bit 0 other, bit 1 self). Offset 0x04 reads the flags.
- R12: An access through a page that names no existing CPU changes nothing, and a read through such a page returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | NUM_IRQ | Level-sensitive hardware interrupt lines |
| bus_cpu | input | CPU_W | Identity of the CPU issuing the register access |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (ignored while wr_en is high) |
| addr | input | ADDR_W | Word address: page in the upper bits, offset in bits 7:0 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one clock after rd_en |
| cpu_irq | output | NUM_CPU | Registered interrupt request per CPU |

## Verification
The hardest case to reach from the ports is a line that is eligible on both CPUs at once and is claimed by one of them. Another read must then show that the second CPU cannot take it, while lower-priority lines and inter-processor flags remain pending. The bench keeps a reference model of masks, triggers, routes and flags. It drives pseudo-random hardware, trigger, routing and mask patterns, and issues event reads from randomly chosen CPUs through both the own page and the explicit pages. Each returned word and each request vector is compared with the model. Directed sequences then stack both flags on top of a shared hardware line to exercise the priority order and the claim-on-read behaviour.

// File: rtl/mp_intc_pkg.sv
package mp_intc_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 8;

  localparam logic [1:0] KIND_HW  = 2'd0;
  localparam logic [1:0] KIND_IPI = 2'd2;

  localparam logic [7:0] OFS_EVENT    = 8'h00;
  localparam logic [7:0] OFS_IPI_SEND = 8'h01;
  localparam logic [7:0] OFS_IPI_SELF = 8'h02;
  localparam logic [7:0] OFS_IPI_CLR  = 8'h03;
  localparam logic [7:0] OFS_IPI_STAT = 8'h04;
  localparam logic [7:0] OFS_MASK_SET = 8'h10;
  localparam logic [7:0] OFS_MASK_CLR = 8'h11;
  localparam logic [7:0] OFS_MASK     = 8'h12;
  localparam logic [7:0] OFS_SWT_SET  = 8'h13;
  localparam logic [7:0] OFS_SWT_CLR  = 8'h14;
  localparam logic [7:0] OFS_SWT      = 8'h15;
  localparam logic [7:0] OFS_PEND     = 8'h16;
  localparam logic [7:0] OFS_AFF_BASE = 8'h40;

  typedef struct packed {
    logic        valid;
    logic [12:0] rsvd;
    logic [1:0]  kind;
    logic [15:0] num;
  } event_t;

  function automatic logic [WORD_W-1:0] make_event(logic [1:0] kind, logic [15:0] num);
    event_t e;
    e.valid = 1'b1;
    e.rsvd  = '0;
    e.kind  = kind;
    e.num   = num;
    return e;
  endfunction
endpackage

// File: rtl/mp_intc_first.sv
module mp_intc_first #(
  parameter int W = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mp_intc_cpu.sv
module mp_intc_cpu
  import mp_intc_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic [NUM_IRQ-1:0] route,
  input  logic [1:0]         ipi,
  output logic               sel_valid,
  output logic [1:0]         sel_kind,
  output logic [15:0]        sel_num,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] eligible;
  logic               hw_found;
  logic [IDX_W-1:0]   hw_idx;

  assign eligible = pend & ~mask & route;

  mp_intc_first #(.W(NUM_IRQ)) u_first (
    .req   (eligible),
    .found (hw_found),
    .idx   (hw_idx)
  );

  always_comb begin
    sel_valid = 1'b0;
    sel_kind  = KIND_HW;
    sel_num   = '0;
    if (ipi[0]) begin
      sel_valid = 1'b1;
      sel_kind  = KIND_IPI;
      sel_num   = 16'd0;
    end else if (ipi[1]) begin
      sel_valid = 1'b1;
      sel_kind  = KIND_IPI;
      sel_num   = 16'd1;
    end else if (hw_found) begin
      sel_valid = 1'b1;
      sel_kind  = KIND_HW;
      sel_num   = 16'(hw_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (|ipi) | hw_found;
  end
endmodule

// File: rtl/mp_intc.sv
module mp_intc
  import mp_intc_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 12,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int PAGE_W = ADDR_W - OFS_W,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] hw_irq,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata,
  output logic [NUM_CPU-1:0] cpu_irq
);
  // controller state
  logic [NUM_IRQ-1:0]              mask_q;
  logic [NUM_IRQ-1:0]              swt_q;
  logic [NUM_IRQ-1:0][NUM_CPU-1:0] aff_q;
  logic [NUM_CPU-1:0][1:0]         ipi_q;

  // address decode
  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] tgt;
  logic [OFS_W-1:0]  ofs;
  logic              tgt_ok;
  logic [OFS_W-1:0]  aff_ofs;
  logic              aff_hit;
  logic [IDX_W-1:0]  aff_sel;

  assign page    = addr[ADDR_W-1:OFS_W];
  assign ofs     = addr[OFS_W-1:0];
  assign tgt     = (page == '0) ? PAGE_W'(bus_cpu) : page - 1'b1;
  assign tgt_ok  = int'(tgt) < NUM_CPU;
  assign aff_ofs = ofs - OFS_AFF_BASE;
  assign aff_hit = (ofs >= OFS_AFF_BASE) && (int'(aff_ofs) < NUM_IRQ);
  assign aff_sel = aff_ofs[IDX_W-1:0];

  logic do_wr;
  logic do_rd;
  assign do_wr = wr_en & tgt_ok;
  assign do_rd = rd_en & ~wr_en;

  // per-CPU selection
  logic [NUM_IRQ-1:0]              pend;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] route;
  logic [NUM_CPU-1:0]              sel_valid;
  logic [NUM_CPU-1:0][1:0]         sel_kind;
  logic [NUM_CPU-1:0][15:0]        sel_num;

  assign pend = hw_irq | swt_q;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        route[c][i] = aff_q[i][c];
      end
    end
  end

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
      mp_intc_cpu #(.NUM_IRQ(NUM_IRQ)) u_cpu (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .mask      (mask_q),
        .route     (route[gc]),
        .ipi       (ipi_q[gc]),
        .sel_valid (sel_valid[gc]),
        .sel_kind  (sel_kind[gc]),
        .sel_num   (sel_num[gc]),
        .irq_o     (cpu_irq[gc])
      );
    end
  endgenerate

  // selection for the addressed CPU
  logic        t_valid;
  logic [1:0]  t_kind;
  logic [15:0] t_num;
  logic [1:0]  t_ipi;
  logic        evt_take;

  always_comb begin
    t_valid = 1'b0;
    t_kind  = KIND_HW;
    t_num   = '0;
    t_ipi   = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (c == int'(tgt)) begin
        t_valid = sel_valid[c];
        t_kind  = sel_kind[c];
        t_num   = sel_num[c];
        t_ipi   = ipi_q[c];
      end
    end
  end

  assign evt_take = do_rd && tgt_ok && (ofs == OFS_EVENT) && t_valid;

  // state update
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      swt_q  <= '0;
      ipi_q  <= '0;
      for (int i = 0; i < NUM_IRQ; i++) aff_q[i] <= NUM_CPU'(1);
    end else if (do_wr) begin
      case (ofs)
        OFS_MASK_SET: mask_q <= mask_q | wdata[NUM_IRQ-1:0];
        OFS_MASK_CLR: mask_q <= mask_q & ~wdata[NUM_IRQ-1:0];
        OFS_SWT_SET:  swt_q  <= swt_q | wdata[NUM_IRQ-1:0];
        OFS_SWT_CLR:  swt_q  <= swt_q & ~wdata[NUM_IRQ-1:0];
        OFS_IPI_SEND: begin
          for (int c = 0; c < NUM_CPU; c++) begin
            if (wdata[c]) ipi_q[c][0] <= 1'b1;
          end
        end
        OFS_IPI_SELF: begin
          for (int c = 0; c < NUM_CPU; c++) begin
            if (c == int'(tgt) && wdata[0]) ipi_q[c][1] <= 1'b1;
          end
        end
        OFS_IPI_CLR: begin
          for (int c = 0; c < NUM_CPU; c++) begin
            if (c == int'(tgt)) ipi_q[c] <= ipi_q[c] & ~wdata[1:0];
          end
        end
        default: begin
          if (aff_hit) aff_q[aff_sel] <= wdata[NUM_CPU-1:0];
        end
      endcase
    end else if (evt_take) begin
      if (t_kind == KIND_IPI) begin
        for (int c = 0; c < NUM_CPU; c++) begin
          if (c == int'(tgt)) ipi_q[c][t_num[0]] <= 1'b0;
        end
      end else begin
        mask_q[t_num[IDX_W-1:0]] <= 1'b1;
      end
    end
  end

  // read path
  logic [WORD_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (tgt_ok) begin
      case (ofs)
        OFS_EVENT:    rd_next = t_valid ? make_event(t_kind, t_num) : '0;
        OFS_IPI_STAT: rd_next = {30'b0, t_ipi};
        OFS_MASK:     rd_next = WORD_W'(mask_q);
        OFS_SWT:      rd_next = WORD_W'(swt_q);
        OFS_PEND:     rd_next = WORD_W'(pend);
        default: begin
          if (aff_hit) rd_next = WORD_W'(aff_q[aff_sel]);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (do_rd) rdata <= rd_next;
  end

  logic unused_bits;
  assign unused_bits = ^{wdata, sel_num};
endmodule

// File: rtl/mp_intc_chk.sv
module mp_intc_chk
  import mp_intc_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 12,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rd_en,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [WORD_W-1:0]       rdata,
  input logic [NUM_CPU-1:0]      cpu_irq,
  input logic [NUM_IRQ-1:0]      mask_q,
  input logic [NUM_CPU-1:0][1:0] ipi_q
);
  logic evt_rd;
  assign evt_rd = rd_en && !wr_en && (addr[OFS_W-1:0] == OFS_EVENT);

  logic unused_page;
  assign unused_page = ^addr[ADDR_W-1:OFS_W];

  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_q)); // R1

  AST_EVENT_FORMAT: assert property (@(posedge clk) disable iff (rst)
    ($past(evt_rd) && rdata[31]) |-> ((rdata[30:18] == '0) &&
      (((rdata[17:16] == KIND_HW) && (int'(rdata[15:0]) < NUM_IRQ)) ||
       ((rdata[17:16] == KIND_IPI) && (rdata[15:0] < 16'd2))))); // R5

  AST_CLAIM_MASKS: assert property (@(posedge clk) disable iff (rst)
    ($past(evt_rd) && rdata[31] && (rdata[17:16] == KIND_HW))
      |-> mask_q[rdata[IDX_W-1:0]]); // R6

  AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (rst)
    ($past(evt_rd) && (rdata == '0)) |-> ($stable(mask_q) && $stable(ipi_q))); // R8

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CPU; gc++) begin : g_quiet
      AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((&$past(mask_q)) && ($past(ipi_q[gc]) == 2'b00)) |-> !cpu_irq[gc]); // R3
    end
  endgenerate
endmodule

bind mp_intc mp_intc_chk #(
  .NUM_IRQ (NUM_IRQ),
  .NUM_CPU (NUM_CPU),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .addr    (addr),
  .rdata   (rdata),
  .cpu_irq (cpu_irq),
  .mask_q  (mask_q),
  .ipi_q   (ipi_q)
);

// File: tb/mp_intc_test.sv
`timescale 1ns/1ps
module mp_intc_test;
  localparam int N  = 16;
  localparam int C  = 2;
  localparam int AW = 12;
  localparam int CW = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  hw_irq = '0;
  logic [CW-1:0] bus_cpu = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [C-1:0]  cpu_irq;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [N-1:0] m_mask;
  logic [N-1:0] m_swt;
  logic [C-1:0] m_aff [N];
  logic [1:0]   m_ipi [C];
  logic [31:0]  lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  mp_intc #(.NUM_IRQ(N), .NUM_CPU(C), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .hw_irq(hw_irq), .bus_cpu(bus_cpu),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cpu_irq(cpu_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(int cpu, int pg, logic [7:0] ofs, logic [31:0] d);
    @(negedge clk);
    bus_cpu = CW'(cpu); addr = {4'(pg), ofs}; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(int cpu, int pg, logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    bus_cpu = CW'(cpu); addr = {4'(pg), ofs}; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(int cpu, int pg, logic [7:0] ofs, logic [31:0] exp, string req);
    logic [31:0] d;
    bus_rd(cpu, pg, ofs, d);
    chk(req, d, exp);
  endtask

  function automatic logic [C-1:0] exp_irq();
    logic [C-1:0] r;
    r = '0;
    for (int c = 0; c < C; c++) begin
      if (m_ipi[c] != 2'b00) r[c] = 1'b1;
      for (int i = 0; i < N; i++) begin
        if ((hw_irq[i] | m_swt[i]) && !m_mask[i] && m_aff[i][c]) r[c] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic irq_chk(string req);
    repeat (2) @(negedge clk);
    chk(req, 32'(cpu_irq), 32'(exp_irq()));
  endtask

  // event read on CPU c, through own page or an explicit page
  task automatic take_event(int c, bit expl, string req);
    logic [31:0] exp;
    logic [31:0] d;
    bit found;
    exp = '0;
    found = 1'b0;
    if (m_ipi[c][0]) begin
      exp = 32'h8002_0000; m_ipi[c][0] = 1'b0;
    end else if (m_ipi[c][1]) begin
      exp = 32'h8002_0001; m_ipi[c][1] = 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!found && (hw_irq[i] | m_swt[i]) && !m_mask[i] && m_aff[i][c]) begin
          found = 1'b1;
          exp = 32'h8000_0000 | 32'(i);
          m_mask[i] = 1'b1;
        end
      end
    end
    if (expl) bus_rd(C - 1 - c, c + 1, 8'h00, d);
    else      bus_rd(c, 0, 8'h00, d);
    chk(req, d, exp);
  endtask

  task automatic mask_set(logic [N-1:0] b); bus_wr(0, 0, 8'h10, 32'(b)); m_mask |= b;  endtask
  task automatic mask_clr(logic [N-1:0] b); bus_wr(0, 0, 8'h11, 32'(b)); m_mask &= ~b; endtask
  task automatic swt_set(logic [N-1:0] b);  bus_wr(1, 0, 8'h13, 32'(b)); m_swt |= b;   endtask
  task automatic swt_clr(logic [N-1:0] b);  bus_wr(1, 0, 8'h14, 32'(b)); m_swt &= ~b;  endtask
  task automatic set_aff(int i, logic [C-1:0] v);
    bus_wr(0, 0, 8'h40 + 8'(i), 32'(v)); m_aff[i] = v;
  endtask
  task automatic ipi_send(logic [C-1:0] t);
    bus_wr(0, 0, 8'h01, 32'(t));
    for (int c = 0; c < C; c++) if (t[c]) m_ipi[c][0] = 1'b1;
  endtask
  task automatic ipi_self(int c);
    bus_wr(c, 0, 8'h02, 32'h1); m_ipi[c][1] = 1'b1;
  endtask
  task automatic ipi_clr(int c, logic [1:0] b);
    bus_wr(c, 0, 8'h03, 32'(b)); m_ipi[c] = m_ipi[c] & ~b;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    m_mask = '1;
    m_swt  = '0;
    for (int i = 0; i < N; i++) m_aff[i] = 2'b01;
    for (int c = 0; c < C; c++) m_ipi[c] = 2'b00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 cpu_irq", 32'(cpu_irq), 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rd_chk(0, 0, 8'h12, 32'h0000_FFFF, "R1 mask");
    rd_chk(0, 0, 8'h15, 32'h0, "R1 trigger");
    rd_chk(0, 0, 8'h04, 32'h0, "R1 ipi cpu0");
    rd_chk(1, 0, 8'h04, 32'h0, "R1 ipi cpu1");
    rd_chk(0, 0, 8'h40, 32'h1, "R1 route 0");
    rd_chk(0, 0, 8'h4F, 32'h1, "R1 route 15");

    // R3: all lines high but masked
    hw_irq = '1;
    irq_chk("R3 masked quiet");
    chk("R3 literal", 32'(cpu_irq), 32'h0);

    // R8: empty event read changes nothing
    take_event(0, 1'b0, "R8 empty");
    rd_chk(0, 0, 8'h12, 32'h0000_FFFF, "R8 mask kept");

    // R10: atomic mask updates
    mask_clr(16'h00F0);
    rd_chk(0, 0, 8'h12, 32'h0000_FF0F, "R10 clear");
    mask_set(16'h0010);
    rd_chk(1, 0, 8'h12, 32'h0000_FF1F, "R10 set");
    irq_chk("R4 cpu0 only route");
    chk("R4 literal", 32'(cpu_irq), 32'h1);
    mask_set('1);

    // R2: software triggers ORed with lines
    hw_irq = '0;
    swt_set(16'h0A05);
    rd_chk(0, 0, 8'h16, 32'h0000_0A05, "R2 pend sw");
    hw_irq = 16'h1000;
    rd_chk(0, 0, 8'h16, 32'h0000_1A05, "R2 pend or");
    swt_clr(16'h0005);
    rd_chk(0, 0, 8'h15, 32'h0000_0A00, "R2 trigger clr");
    rd_chk(1, 2, 8'h16, 32'h0000_1A00, "R2 pend after clr");

    // R4 R5 R6 R9: pseudo-random sweep against model
    for (int it = 0; it < 30; it++) begin
      step_lfsr();
      hw_irq = lfsr[15:0];
      mask_set('1);
      swt_clr('1);
      swt_set(lfsr[31:16] & 16'h0F0F);
      for (int i = 0; i < N; i++) begin
        step_lfsr();
        set_aff(i, lfsr[C-1:0]);
      end
      step_lfsr();
      mask_clr(lfsr[15:0] | lfsr[31:16]);
      irq_chk("R4 sweep");
      for (int k = 0; k < 4; k++) begin
        step_lfsr();
        take_event(int'(lfsr[0]), lfsr[1], "R5 R9 sweep event");
        irq_chk("R6 sweep after claim");
      end
    end

    // R6: shared line claimed once
    mask_set('1);
    swt_clr('1);
    hw_irq = 16'h0220;
    set_aff(5, 2'b11);
    set_aff(9, 2'b10);
    mask_clr(16'h0220);
    irq_chk("R6 both requested");
    take_event(0, 1'b0, "R6 cpu0 claims 5");
    take_event(1, 1'b0, "R6 cpu1 gets 9");
    rd_chk(0, 0, 8'h12, 32'h0000_FFFF, "R6 both masked");

    // R7 R11: inter-processor flags above hardware
    hw_irq = 16'h0008;
    set_aff(3, 2'b11);
    mask_clr(16'h0008);
    ipi_send(2'b10);
    ipi_self(1);
    rd_chk(1, 0, 8'h04, 32'h3, "R11 cpu1 flags");
    rd_chk(0, 0, 8'h04, 32'h0, "R11 cpu0 untouched");
    irq_chk("R4 ipi request");
    take_event(1, 1'b0, "R7 other first");
    take_event(1, 1'b1, "R7 self second");
    take_event(1, 1'b0, "R7 hw after flags");
    rd_chk(1, 0, 8'h04, 32'h0, "R7 flags cleared");
    ipi_send(2'b11);
    ipi_self(0);
    ipi_clr(0, 2'b10);
    rd_chk(0, 0, 8'h04, 32'h1, "R11 clear self only");

    // R9: own page versus explicit pages
    rd_chk(0, 2, 8'h04, 32'h1, "R9 page2 is cpu1");
    rd_chk(1, 0, 8'h04, 32'h1, "R9 own page cpu1");
    ipi_clr(1, 2'b01);
    rd_chk(1, 1, 8'h04, 32'h1, "R9 page1 is cpu0");
    rd_chk(0, 2, 8'h04, 32'h0, "R9 cpu1 cleared");

    // R12: page naming no CPU
    bus_wr(0, 3, 8'h11, 32'hFFFF);
    rd_chk(0, 0, 8'h12, 32'(m_mask), "R12 write ignored");
    rd_chk(0, 3, 8'h12, 32'h0, "R12 read zero");
    irq_chk("R12 requests unchanged");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule